// File: doc/BRIEF.md
# Replay-Protected Block Storage Controller

This block models the command side of a storage partition whose contents can only be changed by authenticated, replay-protected writes. Requests arrive as fixed-format frames, one per clock cycle, and responses come back as frames on a registered output. There are five request kinds: one-time authentication key programming, counter read, authenticated write, authenticated read and result read. The block keeps a one-time key register, a saturating write counter and a small internal memory of 256-byte blocks.

The message authentication check is not computed here. Each frame carries a `mac_ok` flag from an external engine, and the programmed key is handed to that engine on a dedicated output. A write or key-programming sequence is staged and only takes effect when the closing result-read frame arrives. That frame's response reports the outcome and the counter value after the operation. An authenticated read streams one data frame per block on consecutive cycles and echoes the request nonce.

Top module: `rpmb_ctrl`

## Requirements
- R1: After reset there is no response frame, the write counter is 0 and no key is programmed, so `mac_key_o` is all zeros.
- R2: A key frame (op 1) followed by a result read (op 5) stores the key and answers result 0 on the first occasion. Any later key sequence answers 1 and leaves the stored key unchanged. The key never appears in any response frame, only on `mac_key_o`.
- R3: Until a key is stored, an authenticated read answers a single frame (op 4) with result 7 and zero data. A write sequence closed by a result read answers result 7, and nothing is committed.
- R4: A counter read (op 2) answers at once with op 2, result 0, the current counter and the request nonce.
- R5: A write (op 3) takes its address, block count and counter value from its first frame and one data block per frame. The authentication flag is taken from the last frame. The result read commits every block, increments the counter, and answers op 5 with result 0, the new counter, the write address and a zero nonce.
- R6: A complete write sequence is rejected in this priority order: authentication failure gives 2, an expired counter gives 5, a counter value not equal to the current counter gives 3, and a range past the last block gives 4. A rejection writes no data and leaves the counter unchanged.
- R7: The counter stops at its all-ones value. Once there, bit 7 of the result is set in every response frame, including the response of the write that reached it.
- R8: An authenticated read (op 4) of N blocks answers N frames on consecutive cycles, each with the block data, its block address, result 0 and the request nonce. A count of 0 answers one frame with result 1, and a range past the last block answers one frame with result 4.
- R9: A result read with no pending sequence answers result 1 with address 0. A result read that closes a write with fewer frames than its count, or with a count of 0 or above the staging depth, answers 1 with the write address.
- R10: A key, counter-read or read request arriving during a write sequence drops it, so no data is committed.
- R11: Frames arriving while a read burst is being answered, and frames with op codes 0, 6 or 7, produce no response and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request frame present this cycle |
| req_op_i | input | 3 | Request kind: 1 key, 2 counter read, 3 write, 4 read, 5 result read |
| req_key_i | input | 256 | Key carried by a key frame |
| req_nonce_i | input | 128 | Request nonce |
| req_wcnt_i | input | CNT_W | Counter value carried by a write frame |
| req_addr_i | input | 16 | First block address |
| req_bcnt_i | input | 8 | Block count |
| req_data_i | input | 2048 | One 256-byte data block |
| req_mac_ok_i | input | 1 | External authentication check passed for this frame |
| rsp_valid_o | output | 1 | Response frame present |
| rsp_op_o | output | 3 | Response kind (same codes as requests) |
| rsp_result_o | output | 8 | Result code in bits 6:0, counter-expired flag in bit 7 |
| rsp_wcnt_o | output | CNT_W | Write counter value |
| rsp_nonce_o | output | 128 | Echoed nonce, or zero |
| rsp_addr_o | output | 16 | Block address of the frame |
| rsp_data_o | output | 2048 | Block data on read frames, otherwise zero |
| mac_key_o | output | 256 | Stored key, fed to the external authentication engine |

## Verification
The bench goes after the order of rejection checks on writes. A design that tested the counter before authentication would report 3 where 2 is expected. It also exercises the closing result read in its odd states: nothing pending, a short sequence, and a sequence broken by another request. A design that committed eagerly, or kept a stale pending write, would change stored data or answer 0 there. The counter is run into saturation on a narrowed instance. Missing the expired bit on the response of the write that reached the maximum, or letting the counter wrap, both show up in the frames that follow. Frames sent into a running read burst must vanish; a design that accepted them would emit an extra counter-read frame.

// File: rtl/rpmb_pkg.sv
package rpmb_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_KEY    = 3'd1,
    OP_CREAD  = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4,
    OP_RESULT = 3'd5
  } op_e;

  localparam logic [6:0] RC_OK    = 7'd0;
  localparam logic [6:0] RC_GEN   = 7'd1;
  localparam logic [6:0] RC_AUTH  = 7'd2;
  localparam logic [6:0] RC_CNT   = 7'd3;
  localparam logic [6:0] RC_ADDR  = 7'd4;
  localparam logic [6:0] RC_WFAIL = 7'd5;
  localparam logic [6:0] RC_NOKEY = 7'd7;
endpackage

// File: rtl/rpmb_key_reg.sv
module rpmb_key_reg #(
  parameter int KEY_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_i,
  input  logic [KEY_W-1:0] key_i,
  output logic [KEY_W-1:0] key_o,
  output logic             done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_o  <= '0;
      done_o <= 1'b0;
    end else if (prog_i && !done_o) begin
      key_o  <= key_i;
      done_o <= 1'b1;
    end
  end

  // R2: once stored, the key is frozen
  p_key_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(key_o)));
endmodule

// File: rtl/rpmb_wcnt.sv
module rpmb_wcnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             max_o
);
  assign max_o = &cnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (inc_i && !max_o) cnt_o <= cnt_o + 1'b1;
  end

  p_sat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    max_o |=> (max_o && cnt_o == $past(cnt_o)));
endmodule

// File: rtl/rpmb_blk_mem.sv
module rpmb_blk_mem #(
  parameter int NUM_BLK = 4,
  parameter int BLK_W   = 2048,
  parameter int MAX_WR  = 2,
  parameter int ADDR_W  = 16,
  parameter int BCNT_W  = 8,
  localparam int IDX_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_base_i,
  input  logic [BCNT_W-1:0]             wr_cnt_i,
  input  logic [MAX_WR-1:0][BLK_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]             rd_idx_i,
  output logic [BLK_W-1:0]              rd_data_o
);
  logic [NUM_BLK-1:0][BLK_W-1:0] mem_q;
  logic [MAX_WR-1:0][ADDR_W:0]   tgt;
  logic [MAX_WR-1:0]             hit;

  for (genvar j = 0; j < MAX_WR; j++) begin : g_port
    assign tgt[j] = {1'b0, wr_base_i} + (ADDR_W+1)'(j);
    assign hit[j] = wr_en_i && (BCNT_W'(j) < wr_cnt_i) &&
                    (tgt[j] < (ADDR_W+1)'(NUM_BLK));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int j = 0; j < MAX_WR; j++)
        if (hit[j]) mem_q[tgt[j][IDX_W-1:0]] <= wr_data_i[j];
    end
  end

  assign rd_data_o = (rd_idx_i < ADDR_W'(NUM_BLK)) ? mem_q[rd_idx_i[IDX_W-1:0]] : '0;
endmodule

// File: rtl/rpmb_ctrl.sv
module rpmb_ctrl
  import rpmb_pkg::*;
#(
  parameter int NUM_BLK     = 4,
  parameter int MAX_WR      = 2,
  parameter int BLK_BYTES   = 256,
  parameter int KEY_BYTES   = 32,
  parameter int NONCE_BYTES = 16,
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 16,
  parameter int BCNT_W      = 8,
  localparam int BLK_W      = 8 * BLK_BYTES,
  localparam int KEY_W      = 8 * KEY_BYTES,
  localparam int NONCE_W    = 8 * NONCE_BYTES,
  localparam int SIDX_W     = (MAX_WR > 1) ? $clog2(MAX_WR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [2:0]         req_op_i,
  input  logic [KEY_W-1:0]   req_key_i,
  input  logic [NONCE_W-1:0] req_nonce_i,
  input  logic [CNT_W-1:0]   req_wcnt_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [BCNT_W-1:0]  req_bcnt_i,
  input  logic [BLK_W-1:0]   req_data_i,
  input  logic               req_mac_ok_i,
  output logic               rsp_valid_o,
  output logic [2:0]         rsp_op_o,
  output logic [7:0]         rsp_result_o,
  output logic [CNT_W-1:0]   rsp_wcnt_o,
  output logic [NONCE_W-1:0] rsp_nonce_o,
  output logic [ADDR_W-1:0]  rsp_addr_o,
  output logic [BLK_W-1:0]   rsp_data_o,
  output logic [KEY_W-1:0]   mac_key_o
);
  // pending sequence state
  op_e                          pend_q;
  logic [KEY_W-1:0]             pend_key_q;
  logic [ADDR_W-1:0]            wr_addr_q;
  logic [BCNT_W-1:0]            wr_cnt_q, wr_got_q;
  logic [CNT_W-1:0]             wr_ctr_q;
  logic                         wr_mac_q, wr_bad_q;
  logic [MAX_WR-1:0][BLK_W-1:0] stage_q;

  // read burst state
  logic                         rd_active_q;
  logic [ADDR_W-1:0]            rd_addr_q;
  logic [BCNT_W-1:0]            rd_left_q;
  logic [NONCE_W-1:0]           rd_nonce_q;

  logic [CNT_W-1:0] ctr_cnt;
  logic             ctr_max, key_done;
  logic [BLK_W-1:0] mem_rd;
  logic [ADDR_W-1:0] mem_idx;

  logic       accept, is_result, commit, key_prog;
  logic [6:0] res_code, rd_code;
  logic       wr_cont, wr_range_bad, rd_range_bad, bcnt_bad;
  logic [CNT_W-1:0] cnt_after;

  assign accept    = req_valid_i && !rd_active_q;
  assign is_result = accept && (req_op_i == OP_RESULT);
  assign wr_cont   = (pend_q == OP_WRITE) && (wr_got_q < wr_cnt_q);
  assign bcnt_bad  = (req_bcnt_i == '0) || (req_bcnt_i > BCNT_W'(MAX_WR));

  assign wr_range_bad = ({1'b0, wr_addr_q} + (ADDR_W+1)'(wr_cnt_q)) > (ADDR_W+1)'(NUM_BLK);
  assign rd_range_bad = ({1'b0, req_addr_i} + (ADDR_W+1)'(req_bcnt_i)) > (ADDR_W+1)'(NUM_BLK);

  // outcome of a result read
  always_comb begin
    res_code = RC_GEN;
    commit   = 1'b0;
    key_prog = 1'b0;
    unique case (pend_q)
      OP_KEY: begin
        if (!key_done) begin
          res_code = RC_OK;
          key_prog = is_result;
        end
      end
      OP_WRITE: begin
        if (!key_done)                  res_code = RC_NOKEY;
        else if (wr_bad_q || wr_cont)   res_code = RC_GEN;
        else if (!wr_mac_q)             res_code = RC_AUTH;
        else if (ctr_max)               res_code = RC_WFAIL;
        else if (wr_ctr_q != ctr_cnt)   res_code = RC_CNT;
        else if (wr_range_bad)          res_code = RC_ADDR;
        else begin
          res_code = RC_OK;
          commit   = is_result;
        end
      end
      default: res_code = RC_GEN;
    endcase
  end

  always_comb begin
    if (!key_done)         rd_code = RC_NOKEY;
    else if (req_bcnt_i == '0) rd_code = RC_GEN;
    else if (rd_range_bad) rd_code = RC_ADDR;
    else                   rd_code = RC_OK;
  end

  assign cnt_after = commit ? ctr_cnt + 1'b1 : ctr_cnt;
  assign mem_idx   = rd_active_q ? rd_addr_q : req_addr_i;

  rpmb_key_reg #(.KEY_W(KEY_W)) u_key (
    .clk_i, .rst_ni, .prog_i(key_prog), .key_i(pend_key_q),
    .key_o(mac_key_o), .done_o(key_done)
  );

  rpmb_wcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(commit), .cnt_o(ctr_cnt), .max_o(ctr_max)
  );

  rpmb_blk_mem #(
    .NUM_BLK(NUM_BLK), .BLK_W(BLK_W), .MAX_WR(MAX_WR),
    .ADDR_W(ADDR_W), .BCNT_W(BCNT_W)
  ) u_mem (
    .clk_i, .rst_ni, .wr_en_i(commit), .wr_base_i(wr_addr_q),
    .wr_cnt_i(wr_cnt_q), .wr_data_i(stage_q),
    .rd_idx_i(mem_idx), .rd_data_o(mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= OP_NONE;     pend_key_q <= '0;
      wr_addr_q <= '0;       wr_cnt_q <= '0;   wr_got_q <= '0;
      wr_ctr_q <= '0;        wr_mac_q <= 1'b0; wr_bad_q <= 1'b0;
      stage_q <= '0;
      rd_active_q <= 1'b0;   rd_addr_q <= '0;  rd_left_q <= '0; rd_nonce_q <= '0;
      rsp_valid_o <= 1'b0;   rsp_op_o <= '0;   rsp_result_o <= '0;
      rsp_wcnt_o <= '0;      rsp_nonce_o <= '0; rsp_addr_o <= '0; rsp_data_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (rd_active_q) begin
        rsp_valid_o  <= 1'b1;
        rsp_op_o     <= OP_READ;
        rsp_result_o <= {ctr_max, RC_OK};
        rsp_wcnt_o   <= ctr_cnt;
        rsp_nonce_o  <= rd_nonce_q;
        rsp_addr_o   <= rd_addr_q;
        rsp_data_o   <= mem_rd;
        rd_addr_q    <= rd_addr_q + 1'b1;
        rd_left_q    <= rd_left_q - 1'b1;
        rd_active_q  <= rd_left_q > 1;
      end else if (accept) begin
        unique case (req_op_i)
          OP_KEY: begin
            pend_q     <= OP_KEY;
            pend_key_q <= req_key_i;
          end
          OP_CREAD: begin
            pend_q       <= OP_NONE;
            rsp_valid_o  <= 1'b1;
            rsp_op_o     <= OP_CREAD;
            rsp_result_o <= {ctr_max, RC_OK};
            rsp_wcnt_o   <= ctr_cnt;
            rsp_nonce_o  <= req_nonce_i;
            rsp_addr_o   <= '0;
            rsp_data_o   <= '0;
          end
          OP_WRITE: begin
            wr_mac_q <= req_mac_ok_i;  // last frame's flag stands
            if (wr_cont) begin
              stage_q[wr_got_q[SIDX_W-1:0]] <= req_data_i;
              wr_got_q <= wr_got_q + 1'b1;
            end else begin
              pend_q     <= OP_WRITE;
              wr_addr_q  <= req_addr_i;
              wr_ctr_q   <= req_wcnt_i;
              wr_bad_q   <= bcnt_bad;
              wr_cnt_q   <= bcnt_bad ? BCNT_W'(1) : req_bcnt_i;
              stage_q[0] <= req_data_i;
              wr_got_q   <= BCNT_W'(1);
            end
          end
          OP_READ: begin
            pend_q       <= OP_NONE;
            rsp_valid_o  <= 1'b1;
            rsp_op_o     <= OP_READ;
            rsp_result_o <= {ctr_max, rd_code};
            rsp_wcnt_o   <= ctr_cnt;
            rsp_nonce_o  <= req_nonce_i;
            rsp_addr_o   <= req_addr_i;
            rsp_data_o   <= (rd_code == RC_OK) ? mem_rd : '0;
            if (rd_code == RC_OK) begin
              rd_addr_q   <= req_addr_i + 1'b1;
              rd_left_q   <= req_bcnt_i - 1'b1;
              rd_active_q <= req_bcnt_i > 1;
              rd_nonce_q  <= req_nonce_i;
            end
          end
          OP_RESULT: begin
            pend_q       <= OP_NONE;
            rsp_valid_o  <= 1'b1;
            rsp_op_o     <= OP_RESULT;
            rsp_result_o <= {&cnt_after, res_code};
            rsp_wcnt_o   <= cnt_after;
            rsp_nonce_o  <= '0;
            rsp_addr_o   <= (pend_q == OP_WRITE) ? wr_addr_q : '0;
            rsp_data_o   <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  p_counter_moves_only_on_ok_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctr_cnt) |-> (rsp_valid_o && rsp_op_o == OP_RESULT && rsp_result_o[6:0] == RC_OK));

  p_result_nonce_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_op_o == OP_RESULT) |-> (rsp_nonce_o == '0));

  p_read_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_op_o == OP_READ && !key_done) |-> (rsp_result_o[6:0] == RC_NOKEY));

  p_expired_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && ctr_max) |-> rsp_result_o[7]);

  p_burst_continues_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active_q |=> (rsp_valid_o && rsp_op_o == OP_READ));
endmodule

// File: tb/tb_rpmb_ctrl.sv
module tb_rpmb_ctrl;
  localparam int NUM_BLK = 4;
  localparam int MAX_WR  = 2;
  localparam int CNT_W   = 3;
  localparam int ADDR_W  = 16;
  localparam int BCNT_W  = 8;
  localparam int BLK_W   = 2048;
  localparam int KEY_W   = 256;
  localparam int NONCE_W = 128;
  localparam int CMAX    = (1 << CNT_W) - 1;

  typedef struct packed {
    logic [7:0]         rq;
    logic [2:0]         op;
    logic [7:0]         res;
    logic [CNT_W-1:0]   cnt;
    logic [NONCE_W-1:0] nonce;
    logic [ADDR_W-1:0]  addr;
    logic [BLK_W-1:0]   data;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic               req_valid = 1'b0, req_mac = 1'b0;
  logic [2:0]         req_op = '0;
  logic [KEY_W-1:0]   req_key = '0;
  logic [NONCE_W-1:0] req_nonce = '0;
  logic [CNT_W-1:0]   req_wcnt = '0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [BCNT_W-1:0]  req_bcnt = '0;
  logic [BLK_W-1:0]   req_data = '0;

  logic               rsp_valid;
  logic [2:0]         rsp_op;
  logic [7:0]         rsp_result;
  logic [CNT_W-1:0]   rsp_wcnt;
  logic [NONCE_W-1:0] rsp_nonce;
  logic [ADDR_W-1:0]  rsp_addr;
  logic [BLK_W-1:0]   rsp_data;
  logic [KEY_W-1:0]   mac_key;

  int checks = 0, errors = 0;
  exp_t exp_q[$];
  int m_cnt = 0;
  bit m_key = 0;
  logic [BLK_W-1:0] m_mem [NUM_BLK];

  always #10 clk = ~clk;

  rpmb_ctrl #(.NUM_BLK(NUM_BLK), .MAX_WR(MAX_WR), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_key_i(req_key), .req_nonce_i(req_nonce), .req_wcnt_i(req_wcnt),
    .req_addr_i(req_addr), .req_bcnt_i(req_bcnt), .req_data_i(req_data),
    .req_mac_ok_i(req_mac), .rsp_valid_o(rsp_valid), .rsp_op_o(rsp_op),
    .rsp_result_o(rsp_result), .rsp_wcnt_o(rsp_wcnt), .rsp_nonce_o(rsp_nonce),
    .rsp_addr_o(rsp_addr), .rsp_data_o(rsp_data), .mac_key_o(mac_key)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [BLK_W-1:0] pat(input int seed);
    logic [BLK_W-1:0] v;
    for (int i = 0; i < BLK_W / 32; i++)
      v[i*32 +: 32] = 32'(seed) * 32'h9E37_79B9 + 32'(i) * 32'h0100_0193 + 32'h5A5A_0001;
    return v;
  endfunction

  function automatic logic [7:0] flag(input int c);
    return (c == CMAX) ? 8'h80 : 8'h00;
  endfunction

  task automatic push(input int rq, input logic [2:0] op, input logic [7:0] res, input int cnt,
                      input logic [NONCE_W-1:0] nonce, input int addr, input logic [BLK_W-1:0] data);
    exp_t e;
    e.rq = 8'(rq); e.op = op; e.res = res; e.cnt = CNT_W'(cnt);
    e.nonce = nonce; e.addr = ADDR_W'(addr); e.data = data;
    exp_q.push_back(e);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11", "unexpected response op", 256'(rsp_op), 256'(0));
      end else begin
        exp_t e;
        string r;
        e = exp_q.pop_front();
        r = $sformatf("R%0d", e.rq);
        chk(rsp_op == e.op, r, "op", 256'(rsp_op), 256'(e.op));
        chk(rsp_result == e.res, r, "result", 256'(rsp_result), 256'(e.res));
        chk(rsp_wcnt == e.cnt, r, "counter", 256'(rsp_wcnt), 256'(e.cnt));
        chk(rsp_nonce == e.nonce, r, "nonce", 256'(rsp_nonce), 256'(e.nonce));
        chk(rsp_addr == e.addr, r, "addr", 256'(rsp_addr), 256'(e.addr));
        chk(rsp_data == e.data, r, "data[255:0]", rsp_data[255:0], e.data[255:0]);
      end
    end
  end

  task automatic send(input logic [2:0] op, input logic [KEY_W-1:0] key, input logic [NONCE_W-1:0] nonce,
                      input int wcnt, input int addr, input int bcnt, input logic [BLK_W-1:0] data, input bit mac);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_key = key; req_nonce = nonce;
    req_wcnt = CNT_W'(wcnt); req_addr = ADDR_W'(addr); req_bcnt = BCNT_W'(bcnt);
    req_data = data; req_mac = mac;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic result_only(input logic [6:0] code, input int addr, input int rq);
    send(3'd5, '0, 128'hDEAD, 0, 0, 0, '0, 1'b0);
    push(rq, 3'd5, flag(m_cnt) | {1'b0, code}, m_cnt, '0, addr, '0);
    idle(2);
  endtask

  task automatic cread(input logic [NONCE_W-1:0] nonce, input int rq);
    send(3'd2, '0, nonce, 0, 0, 0, '0, 1'b0);
    push(rq, 3'd2, flag(m_cnt), m_cnt, nonce, 0, '0);
    idle(2);
  endtask

  task automatic rd(input int addr, input int bcnt, input logic [NONCE_W-1:0] nonce, input int rq);
    logic [6:0] code;
    if (!m_key)                  code = 7'd7;
    else if (bcnt == 0)          code = 7'd1;
    else if (addr + bcnt > NUM_BLK) code = 7'd4;
    else                         code = 7'd0;
    if (code == 0)
      for (int i = 0; i < bcnt; i++) push(rq, 3'd4, flag(m_cnt), m_cnt, nonce, addr + i, m_mem[addr + i]);
    else
      push(rq, 3'd4, flag(m_cnt) | {1'b0, code}, m_cnt, nonce, addr, '0);
    send(3'd4, '0, nonce, 0, addr, bcnt, '0, 1'b0);
    idle(bcnt + 2);
  endtask

  // nframes data frames, then the closing result read
  task automatic wr_seq(input int addr, input int bcnt, input int nframes, input int ctr, input bit mac,
                        input int seed, input logic [6:0] code, input int rq);
    int nc;
    for (int i = 0; i < nframes; i++)
      send(3'd3, '1, 128'hF00D + 128'(i), ctr, addr, bcnt, pat(seed + i), (i == nframes - 1) ? mac : 1'b0);
    send(3'd5, '0, 128'hBEEF, 0, 0, 0, '0, 1'b0);
    nc = (code == 0) ? m_cnt + 1 : m_cnt;
    push(rq, 3'd5, flag(nc) | {1'b0, code}, nc, '0, addr, '0);
    if (code == 0) begin
      for (int i = 0; i < bcnt; i++) m_mem[addr + i] = pat(seed + i);
      m_cnt = nc;
    end
    idle(2);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [KEY_W-1:0] K1 = {8{32'hC0FF_EE11}};
  localparam logic [KEY_W-1:0] K2 = {8{32'h1234_5678}};

  initial begin
    for (int i = 0; i < NUM_BLK; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 256'(rsp_valid), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 256'(rsp_valid), 256'(0));
    chk(mac_key == '0, "R1", "key after reset", mac_key, '0);

    cread(128'h1111_2222, 4);                        // R4 counter read before key
    rd(0, 1, 128'hAAAA, 3);                          // R3 read gated
    wr_seq(0, 1, 1, 0, 1'b1, 1, 7'd7, 3);            // R3 write gated
    result_only(7'd1, 0, 9);                         // R9 nothing pending

    // R2 key programming, once only
    send(3'd1, K1, 128'h77, 0, 0, 0, '0, 1'b0);
    result_only(7'd0, 0, 2);
    m_key = 1;
    chk(mac_key == K1, "R2", "stored key", mac_key, K1);
    send(3'd1, K2, 128'h78, 0, 0, 0, '0, 1'b0);
    result_only(7'd1, 0, 2);
    chk(mac_key == K1, "R2", "key after second attempt", mac_key, K1);

    wr_seq(1, 2, 2, 0, 1'b1, 10, 7'd0, 5);           // R5 two-block write
    rd(1, 2, 128'hABCD_0001, 8);                     // R8 two-frame read
    cread(128'h5, 4);                                // R4 counter now 1

    wr_seq(1, 2, 2, 1, 1'b0, 20, 7'd2, 6);           // R6 auth failure
    wr_seq(1, 1, 1, 5, 1'b1, 30, 7'd3, 6);           // R6 counter mismatch
    wr_seq(1, 1, 1, 5, 1'b0, 31, 7'd2, 6);           // R6 auth before counter
    wr_seq(3, 2, 2, 1, 1'b1, 40, 7'd4, 6);           // R6 range
    rd(1, 2, 128'h66, 6);                            // R6 data untouched
    rd(3, 2, 128'h81, 8);                            // R8 range error
    rd(0, 0, 128'h82, 8);                            // R8 zero count

    wr_seq(0, 2, 1, 1, 1'b1, 50, 7'd1, 9);           // R9 short sequence
    wr_seq(0, 3, 1, 1, 1'b1, 51, 7'd1, 9);           // R9 count above staging

    // R10: counter read aborts a complete write
    send(3'd3, '0, 128'h1, 1, 0, 1, pat(60), 1'b1);
    send(3'd2, '0, 128'h2, 0, 0, 0, '0, 1'b0);
    push(10, 3'd2, flag(m_cnt), m_cnt, 128'h2, 0, '0);
    result_only(7'd1, 0, 10);
    rd(0, 1, 128'h3, 10);

    // R11: request inside a read burst is dropped
    push(11, 3'd4, flag(m_cnt), m_cnt, 128'h44, 1, m_mem[1]);
    push(11, 3'd4, flag(m_cnt), m_cnt, 128'h44, 2, m_mem[2]);
    send(3'd4, '0, 128'h44, 0, 1, 2, '0, 1'b0);
    send(3'd2, '0, 128'h45, 0, 0, 0, '0, 1'b0);
    idle(3);
    // R11: undefined op codes
    send(3'd6, K2, 128'h46, 0, 0, 1, '0, 1'b1);
    send(3'd0, K2, 128'h47, 0, 0, 1, '0, 1'b1);
    send(3'd7, K2, 128'h48, 0, 0, 1, '0, 1'b1);
    idle(3);
    cread(128'h49, 11);

    // R7 saturation
    for (int s = 0; m_cnt < CMAX; s++) wr_seq(0, 1, 1, m_cnt, 1'b1, 100 + s, 7'd0, 7);
    cread(128'h99, 7);
    wr_seq(0, 1, 1, m_cnt, 1'b1, 200, 7'd5, 7);      // R7 expired write fails
    rd(0, 1, 128'h9A, 7);

    idle(4);
    chk(exp_q.size() == 0, "R8", "missing responses", 256'(exp_q.size()), 256'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule